// File: doc/BRIEF.md
# Serial Byte Memory Target on a Two-Wire Bus

This block is a target on a two-wire serial bus (I2C). It looks like a small byte-addressed memory. The bus controller writes bytes into a 2^ADDR_W-entry array and reads them back. Both bus lines are sampled in the system clock domain. Each line is cleaned by a synchronizer and a majority vote. The filtered lines are then watched for start, repeated start and stop conditions. The block pulls SDA low through an open-drain enable output, `sda_oe`. It never drives the line high.

Every access goes through one persistent address pointer, and that pointer moves on by one after every completed byte. A read control byte with no preceding address returns the byte that follows the last one touched. To read a chosen address, the controller first sends a write control byte and a word address, then issues a repeated start followed by a read control byte. While the controller acknowledges each data byte, the block keeps sending the next byte. A not-acknowledge followed by a stop ends the read. A write control byte followed by a word address and data bytes stores those bytes one after another from that address.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe` is 0 and the block is idle with the pointer at address 0.
- R2: Each line passes through a synchronizer and a 3-tap majority vote. An SDA pulse lasting one system clock while SCL is high is neither a start nor a stop, and it does not corrupt the byte in progress.
- R3: A control byte is accepted only when bits 7:4 equal 4'b1010 and bits 3:1 equal CHIP_SEL. Otherwise the block gives no acknowledge, keeps `sda_oe` at 0 and waits for the next start. A start or a stop always releases SDA on the following cycle.
- R4: With IGNORE_CS set, bits 3:1 of the control byte are not compared, and any chip-select value is accepted.
- R5: With bit 0 of the control byte at 0, the next byte is the word address and is loaded into the pointer. Each following data byte is stored at the pointer. The block acknowledges the control, address and data bytes by pulling SDA low during the ninth clock.
- R6: A read control byte (bit 0 at 1) is acknowledged, and the byte at the pointer is then sent MSB first, with SDA changing only while SCL is low.
- R7: Address, repeated start, then read control byte returns the byte stored at that address.
- R8: While the controller acknowledges a read byte, the next byte at pointer+1 follows.
- R9: The pointer increments by one after every completed read or written byte and wraps from the top address to 0.
- R10: A not-acknowledge and a stop end a read with SDA released. A later read that carries no address continues at the byte after the last one sent.
- R11: Several data bytes in one write sequence land at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench writes a single byte and a three-byte burst. It then reads them back four ways: random single reads, reads with no address after a not-acknowledge, an acknowledged sequential run and a run across the top address. Comparing these access types shows whether the pointer is loaded, advanced or left alone at each step. Control bytes with a wrong chip select and with a wrong device code are followed by a write whose target address is read back later. This separates a block that ignores such bytes from one that only withholds the acknowledge. A one-cycle SDA glitch in the middle of a data bit, and a second target instance with chip-select comparison disabled, cover the filter and the don't-care option.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    // upper seven bits of the control byte: code, select
    function automatic logic ctrl_hit(input logic [6:0] hdr,
                                      input logic [3:0] code,
                                      input logic [2:0] sel,
                                      input logic       any_sel);
        return (hdr[6:3] == code) && (any_sel || (hdr[2:0] == sel));
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int HALF = VOTE_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   vote_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            vote_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            dout   <= ($countones(vote_q) > HALF);
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_mem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.start    = scl_f && scl_p && sda_p && !sda_f;
        ev.stop     = scl_f && scl_p && !sda_p && sda_f;
        ev.scl_rise = scl_f && !scl_p;
        ev.scl_fall = !scl_f && scl_p;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter logic [2:0] CHIP_SEL    = 3'b000,
    parameter bit         IGNORE_CS   = 1'b0,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int LINES = 2;
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] FULL     = 4'(BYTE_W);

    logic [LINES-1:0] raw_lines, flt_lines;
    logic             scl_f, sda_f;
    bus_evt_t         ev;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_flt
            i2c_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .VOTE_TAPS  (VOTE_TAPS)
            ) flt_i (
                .clk (clk),
                .rst (rst),
                .din (raw_lines[g]),
                .dout(flt_lines[g])
            );
        end
    endgenerate

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    i2c_bus_events evt_i (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .ev   (ev)
    );

    tgt_state_t        st;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, mem_rd;
    logic [ADDR_W-1:0] ptr;
    logic              rd_mode, m_ack;
    logic              mem_we, ptr_inc, ptr_load;
    logic              start_det, stop_det;

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_mem_array #(.ADDR_W(ADDR_W)) mem_i (
        .clk  (clk),
        .rst  (rst),
        .we   (mem_we),
        .addr (ptr),
        .wdata(rx_sh),
        .rdata(mem_rd)
    );

    always_comb begin
        mem_we   = (st == ST_WDATA) && ev.scl_fall && (bit_cnt == FULL);
        ptr_load = (st == ST_ADDR) && ev.scl_fall && (bit_cnt == FULL);
        ptr_inc  = mem_we ||
                   ((st == ST_RDATA) && ev.scl_fall && (bit_cnt == LAST_BIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= rx_sh[ADDR_W-1:0];
        end else if (ptr_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rd_mode <= 1'b0;
            m_ack   <= 1'b0;
        end else if (ev.start) begin
            st      <= ST_CTRL;
            bit_cnt <= '0;
        end else if (ev.stop) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (ev.scl_rise && bit_cnt < FULL) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.scl_fall && bit_cnt == FULL) begin
                        if (st == ST_CTRL) begin
                            if (ctrl_hit(rx_sh[7:1], DEV_CODE, CHIP_SEL, IGNORE_CS)) begin
                                rd_mode <= rx_sh[0];
                                tx_sh   <= mem_rd;
                                st      <= ST_CTRL_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_ADDR) begin
                            st <= ST_ADDR_ACK;
                        end else begin
                            st <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (ev.scl_fall) begin
                        st      <= rd_mode ? ST_RDATA : ST_ADDR;
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (ev.scl_fall) begin
                        st      <= ST_WDATA;
                        bit_cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            st <= ST_RACK;
                        end else begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        m_ack <= !ev.sda;
                    end else if (ev.scl_fall) begin
                        if (m_ack) begin
                            tx_sh   <= mem_rd;
                            bit_cnt <= '0;
                            st      <= ST_RDATA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = (st == ST_CTRL_ACK) || (st == ST_ADDR_ACK) ||
                    (st == ST_WDATA_ACK) || ((st == ST_RDATA) && !tx_sh[BYTE_W-1]);

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_f,
    input logic              start_det,
    input logic              stop_det,
    input logic              ptr_inc,
    input logic [ADDR_W-1:0] ptr
);
    // R1
    reset_release_chk: assert property (@(posedge clk) $past(rst) |-> !sda_oe);

    // R6
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);

    // R3
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_inc |=> ptr == ADDR_W'($past(ptr) + 1'b1));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .scl_f    (scl_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .ptr_inc  (ptr_inc),
    .ptr      (ptr)
);

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic en_b = 1'b0;
    logic oe_a, oe_b;
    logic sda_line;
    bit   done = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~oe_a & ~(en_b & oe_b);

    i2c_mem_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe_a)
    );

    i2c_mem_target #(.CHIP_SEL(3'b011), .IGNORE_CS(1'b1)) dut_any_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ctl(input logic [2:0] cs, input logic rw);
        return {4'b1010, cs, rw};
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                logic [7:0] e, o;
                string t;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                t = tag_q.pop_front();
                check(o == e, t, o, e);
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(Q);
        scl   = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        scl   = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(Q);
        scl   = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(Q);
    endtask

    task automatic clk_bit(input logic b, input bit glitch, output logic o);
        m_sda = b; wait_q(Q);
        scl = 1'b1; wait_q(Q / 2);
        if (glitch) begin
            m_sda = 1'b0; wait_q(1); m_sda = b;
        end
        wait_q(Q / 2);
        o = sda_line;
        wait_q(Q);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
        logic o;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], glitch && (i == 7), o);
        clk_bit(1'b1, 1'b0, o);
        acked = (o == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack);
        logic [7:0] v;
        logic o;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, o);
            v[i] = o;
        end
        clk_bit(give_ack ? 1'b0 : 1'b1, 1'b0, o);
        obs_q.push_back(v);
    endtask

    task automatic write_seq(input logic [2:0] cs, input logic [7:0] a,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, input string t);
        bit k;
        bus_start();
        send_byte(ctl(cs, 1'b0), 1'b0, k); check(k, t, k, 1);
        send_byte(a, 1'b0, k);             check(k, t, k, 1);
        send_byte(d0, 1'b0, k);            check(k, t, k, 1);
        if (n > 1) begin send_byte(d1, 1'b0, k); check(k, t, k, 1); end
        if (n > 2) begin send_byte(d2, 1'b0, k); check(k, t, k, 1); end
        bus_stop();
    endtask

    task automatic rand_read(input logic [2:0] cs, input logic [7:0] a, input int n, input string t);
        bit k;
        bus_start();
        send_byte(ctl(cs, 1'b0), 1'b0, k); check(k, t, k, 1);
        send_byte(a, 1'b0, k);             check(k, t, k, 1);
        m_sda = 1'b1; wait_q(Q);
        bus_start();
        send_byte(ctl(cs, 1'b1), 1'b0, k); check(k, t, k, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1);
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string t);
        bit k;
        bus_start();
        send_byte(ctl(3'b000, 1'b1), 1'b0, k); check(k, t, k, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1);
        bus_stop();
    endtask

    initial begin
        bit k;
        wait_q(5);
        check(oe_a == 1'b0, "R1", oe_a, 0);
        rst = 1'b0;
        wait_q(10);
        check(oe_a == 1'b0, "R1", oe_a, 0);
        // R1: pointer starts at 0, array cleared
        expect_byte(8'h00, "R1");
        cur_read(1, "R1");

        // R5 single byte write, R11 burst write
        write_seq(3'b000, 8'h10, 8'hA5, 8'h00, 8'h00, 1, "R5");
        write_seq(3'b000, 8'h20, 8'h11, 8'h22, 8'h33, 3, "R11");

        // R7 random read, then R6 / R10 current reads continue
        expect_byte(8'h11, "R7");
        rand_read(3'b000, 8'h20, 1, "R7");
        check(oe_a == 1'b0 && sda_line == 1'b1, "R10", oe_a, 0);
        expect_byte(8'h22, "R10");
        cur_read(1, "R6");
        expect_byte(8'h33, "R6");
        cur_read(1, "R6");
        expect_byte(8'hA5, "R5");
        rand_read(3'b000, 8'h10, 1, "R5");

        // R8 sequential read, MSB first
        expect_byte(8'h11, "R8");
        expect_byte(8'h22, "R8");
        expect_byte(8'h33, "R8");
        rand_read(3'b000, 8'h20, 3, "R8");

        // R9 wrap across the top address
        write_seq(3'b000, 8'hFF, 8'h5A, 8'hC3, 8'h00, 2, "R9");
        expect_byte(8'h5A, "R9");
        expect_byte(8'hC3, "R9");
        rand_read(3'b000, 8'hFF, 2, "R9");
        expect_byte(8'h00, "R9");
        cur_read(1, "R9");

        // R3 wrong chip select and wrong device code: no ack, no store
        bus_start();
        send_byte(ctl(3'b001, 1'b0), 1'b0, k); check(!k, "R3", k, 0);
        send_byte(8'h10, 1'b0, k);             check(!k, "R3", k, 0);
        send_byte(8'hEE, 1'b0, k);             check(!k, "R3", k, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB0, 1'b0, k);             check(!k, "R3", k, 0);
        send_byte(8'h10, 1'b0, k);             check(!k, "R3", k, 0);
        bus_stop();
        expect_byte(8'hA5, "R3");
        rand_read(3'b000, 8'h10, 1, "R3");

        // R2 one-cycle glitch while SCL high in a data bit
        bus_start();
        send_byte(ctl(3'b000, 1'b0), 1'b0, k); check(k, "R2", k, 1);
        send_byte(8'h40, 1'b0, k);             check(k, "R2", k, 1);
        send_byte(8'h96, 1'b1, k);             check(k, "R2", k, 1);
        bus_stop();
        expect_byte(8'h96, "R2");
        rand_read(3'b000, 8'h40, 1, "R2");

        // R4 chip select ignored on second target
        en_b = 1'b1;
        bus_start();
        send_byte(ctl(3'b110, 1'b0), 1'b0, k); check(k, "R4", k, 1);
        send_byte(8'h20, 1'b0, k);             check(k, "R4", k, 1);
        m_sda = 1'b1; wait_q(Q);
        bus_start();
        send_byte(ctl(3'b110, 1'b1), 1'b0, k); check(k, "R4", k, 1);
        expect_byte(8'h11, "R4");
        recv_byte(1'b0);
        bus_stop();
        en_b = 1'b0;

        wait_q(10);
        check(exp_q.size() == 0 && obs_q.size() == 0, "R8", obs_q.size(), exp_q.size());
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (180000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule